// File: doc/BRIEF.md
# Vectored Interrupt Enable Controller

This block sits between five interrupt sources and a CPU core. The sources are external line 0, timer 0, external line 1, timer 1 and the serial unit. The serial unit raises its single request whenever either its receive-complete flag or its transmit-complete flag is high. Every request is masked by its own bit in an 8-bit enable register. Bit 7 of that register is a master enable that overrides all the others. Software writes the register and can read it back.

When at least one request is both pending and enabled, the controller latches one winner, chosen in a fixed order. It then raises `irq_o` and presents that source's fixed vector address. When the CPU acknowledges, the controller drops `irq_o` and sends a one-cycle taken pulse to the chosen source, but only if that source clears its own flag in hardware. The timers always clear their flags this way. An external line does so only when it is configured for edge detection. The serial flags are never cleared by the controller and are left for software. After an acknowledge, no new request is issued until the CPU signals return-from-interrupt.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset the enable register reads 0x00, and `irq_o`, `taken_o` and `vec_addr_o` are all zero.
- R2: When `en_we_i` is high at a clock edge, all eight bits of `en_wdata_i` are stored, and `en_rdata_o` shows them from the next cycle.
- R3: While enable bit 7 is 0, `irq_o` never rises, whatever the requests and source enable bits are.
- R4: Each source has its own enable bit. Bit 0 is external 0, bit 1 is timer 0, bit 2 is external 1, bit 3 is timer 1 and bit 4 is serial. A source whose bit is 0 is never issued, even when it outranks an enabled one.
- R5: While `irq_o` is high, `vec_addr_o` holds the winner's fixed vector: 0x0003 for external 0, 0x000B for timer 0, 0x0013 for external 1, 0x001B for timer 1 and 0x0023 for serial. It reads 0 while `irq_o` is low.
- R6: When several enabled requests are pending together, they are issued in this order: external 0, timer 0, external 1, timer 1, serial.
- R7: The serial request is the OR of `ser_rx_done_i` and `ser_tx_done_i`. Either flag alone produces vector 0x0023.
- R8: An acknowledge (`ack_i` high while `irq_o` is high) gives a single one-cycle pulse on `taken_o`, in the cycle after the acknowledge edge. The pulse appears on bit 1 (timer 0) or bit 3 (timer 1) always. It appears on bit 0 or bit 2 (external 0 or 1) only when `ext_edge_i[0]` or `ext_edge_i[1]` respectively is 1. It never appears on bit 4 (serial).
- R9: `irq_o` is low in the cycle after an acknowledge. It stays low until a `reti_i` pulse, even if requests remain pending. After the pulse, pending requests are issued again.
- R10: If the latched source's request or enable goes away before it is acknowledged, `irq_o` falls in the next cycle and no taken pulse is sent.
- R11: `irq_o` rises one cycle after an enabled request is first seen at a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext0_req_i | input | 1 | External line 0 request flag |
| tmr0_ovf_i | input | 1 | Timer 0 overflow flag |
| ext1_req_i | input | 1 | External line 1 request flag |
| tmr1_ovf_i | input | 1 | Timer 1 overflow flag |
| ser_rx_done_i | input | 1 | Serial receive-complete flag |
| ser_tx_done_i | input | 1 | Serial transmit-complete flag |
| ext_edge_i | input | 2 | Edge-detect mode for external lines 1 and 0 (hardware clears the flag) |
| en_we_i | input | 1 | Enable register write strobe |
| en_wdata_i | input | 8 | Enable register write data |
| en_rdata_o | output | 8 | Enable register contents |
| vec_addr_o | output | 16 | Vector of the issued request |
| irq_o | output | 1 | Interrupt request to the CPU |
| ack_i | input | 1 | CPU acknowledge |
| taken_o | output | 5 | Per-source vector-taken pulse |
| reti_i | input | 1 | Return-from-interrupt pulse |

## Verification
The selection logic is tested with the following request patterns:
- A single timer request held while the master bit is clear and then set. This separates master gating from source gating.
- All five requests raised at once, then withdrawn one by one as each is serviced. This fixes the whole priority order and the per-source taken behaviour, and it covers external lines in both level and edge mode.
- A high-ranked request whose enable bit is clear, raised beside a lower-ranked enabled one. This shows that masking comes before ranking.
- Each serial flag on its own. This shows the OR merge.
- A request withdrawn before acknowledge. This separates a withdrawn request from one that is held and serviced.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  parameter int unsigned NSRC       = 5;
  parameter int unsigned ADDR_W     = 16;
  parameter int unsigned EN_W       = 8;
  parameter int unsigned GLB_BIT    = 7;
  parameter int unsigned VEC_BASE   = 3;
  parameter int unsigned VEC_STRIDE = 8;
  localparam int unsigned IDX_W     = $clog2(NSRC);

  // source index doubles as rank: lower index wins
  localparam int unsigned SRC_EXT0 = 0;
  localparam int unsigned SRC_TMR0 = 1;
  localparam int unsigned SRC_EXT1 = 2;
  localparam int unsigned SRC_TMR1 = 3;
  localparam int unsigned SRC_SER  = 4;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_SVC  = 2'd2
  } seq_st_e;

  function automatic logic [ADDR_W-1:0] vec_of(input logic [IDX_W-1:0] idx);
    int unsigned v;
    v = VEC_BASE + VEC_STRIDE * int'(idx);
    return ADDR_W'(v);
  endfunction
endpackage

// File: rtl/irq_en_reg.sv
module irq_en_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_q <= '0;
    else if (we_i) q_q <= wdata_i;
  end

  assign q_o = q_q;
endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel
  import irq_vec_pkg::*;
(
  input  logic [NSRC-1:0]  req_i,
  input  logic [EN_W-1:0]  en_i,
  output logic [NSRC-1:0]  gated_o,
  output logic             any_o,
  output logic [IDX_W-1:0] win_o
);
  for (genvar i = 0; i < NSRC; i++) begin : g_gate
    assign gated_o[i] = req_i[i] & en_i[i] & en_i[GLB_BIT];
  end

  assign any_o = |gated_o;

  // scan high to low so the lowest pending index is left standing
  always_comb begin
    win_o = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (gated_o[i]) win_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/irq_seq.sv
module irq_seq
  import irq_vec_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             any_i,
  input  logic [IDX_W-1:0] win_i,
  input  logic [NSRC-1:0]  gated_i,
  input  logic [NSRC-1:0]  autoclr_i,
  input  logic             ack_i,
  input  logic             reti_i,
  output logic             irq_o,
  output logic [IDX_W-1:0] sel_o,
  output logic [NSRC-1:0]  taken_o
);
  seq_st_e          st_q;
  logic [IDX_W-1:0] sel_q;
  logic [NSRC-1:0]  taken_q;
  logic [NSRC-1:0]  sel_1h;

  assign sel_1h = NSRC'(1) << sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      sel_q   <= '0;
      taken_q <= '0;
    end else begin
      taken_q <= '0;
      unique case (st_q)
        ST_IDLE: begin
          if (any_i) begin
            sel_q <= win_i;
            st_q  <= ST_REQ;
          end
        end
        ST_REQ: begin
          if (ack_i) begin
            taken_q <= sel_1h & autoclr_i;
            st_q    <= ST_SVC;
          end else if (!gated_i[sel_q]) begin
            st_q <= ST_IDLE;  // request withdrawn before ack
          end
        end
        ST_SVC: begin
          if (reti_i) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign irq_o   = (st_q == ST_REQ);
  assign sel_o   = sel_q;
  assign taken_o = taken_q;
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
  import irq_vec_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        ext0_req_i,
  input  logic        tmr0_ovf_i,
  input  logic        ext1_req_i,
  input  logic        tmr1_ovf_i,
  input  logic        ser_rx_done_i,
  input  logic        ser_tx_done_i,
  input  logic [1:0]  ext_edge_i,
  input  logic        en_we_i,
  input  logic [7:0]  en_wdata_i,
  output logic [7:0]  en_rdata_o,
  output logic [15:0] vec_addr_o,
  output logic        irq_o,
  input  logic        ack_i,
  output logic [4:0]  taken_o,
  input  logic        reti_i
);
  logic [EN_W-1:0]  en_q;
  logic [NSRC-1:0]  req;
  logic [NSRC-1:0]  autoclr;
  logic [NSRC-1:0]  gated;
  logic             any;
  logic [IDX_W-1:0] win;
  logic [IDX_W-1:0] sel;
  logic             irq;

  always_comb begin
    req               = '0;
    req[SRC_EXT0]     = ext0_req_i;
    req[SRC_TMR0]     = tmr0_ovf_i;
    req[SRC_EXT1]     = ext1_req_i;
    req[SRC_TMR1]     = tmr1_ovf_i;
    req[SRC_SER]      = ser_rx_done_i | ser_tx_done_i;
    autoclr           = '0;
    autoclr[SRC_EXT0] = ext_edge_i[0];
    autoclr[SRC_TMR0] = 1'b1;
    autoclr[SRC_EXT1] = ext_edge_i[1];
    autoclr[SRC_TMR1] = 1'b1;
    autoclr[SRC_SER]  = 1'b0;  // software clears serial flags
  end

  irq_en_reg #(.W(EN_W)) u_en (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (en_we_i),
    .wdata_i(en_wdata_i),
    .q_o    (en_q)
  );

  irq_prio_sel u_sel (
    .req_i  (req),
    .en_i   (en_q),
    .gated_o(gated),
    .any_o  (any),
    .win_o  (win)
  );

  irq_seq u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .any_i    (any),
    .win_i    (win),
    .gated_i  (gated),
    .autoclr_i(autoclr),
    .ack_i    (ack_i),
    .reti_i   (reti_i),
    .irq_o    (irq),
    .sel_o    (sel),
    .taken_o  (taken_o)
  );

  assign en_rdata_o = en_q;
  assign irq_o      = irq;
  assign vec_addr_o = irq ? vec_of(sel) : '0;
endmodule

// File: rtl/irq_vec_chk.sv
module irq_vec_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        ext0_req_i,
  input logic        tmr0_ovf_i,
  input logic        ext1_req_i,
  input logic        tmr1_ovf_i,
  input logic        ser_rx_done_i,
  input logic        ser_tx_done_i,
  input logic [1:0]  ext_edge_i,
  input logic        en_we_i,
  input logic [7:0]  en_wdata_i,
  input logic [7:0]  en_rdata_o,
  input logic [15:0] vec_addr_o,
  input logic        irq_o,
  input logic        ack_i,
  input logic [4:0]  taken_o,
  input logic        reti_i
);
  logic in_svc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               in_svc <= 1'b0;
    else if (irq_o && ack_i)   in_svc <= 1'b1;
    else if (reti_i)           in_svc <= 1'b0;
  end

  p_global_gate_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(en_rdata_o[7]));

  p_vec_zero_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o |-> (vec_addr_o == 16'h0000));

  p_vec_stable_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && $past(irq_o)) |-> $stable(vec_addr_o));

  p_taken_onehot_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(taken_o));

  p_taken_after_ack_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|taken_o) |-> $past(ack_i && irq_o));

  p_taken_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|taken_o) |=> !(|taken_o));

  p_serial_no_taken_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !taken_o[4]);

  p_drop_after_ack_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && ack_i) |=> !irq_o);

  p_quiet_in_svc_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_svc |-> !irq_o);
endmodule

bind irq_vec_ctrl irq_vec_chk u_chk (.*);

// File: tb/tb_irq_vec_ctrl.sv
`timescale 1ns/1ps
module tb_irq_vec_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ext0_req_i = 0, tmr0_ovf_i = 0, ext1_req_i = 0, tmr1_ovf_i = 0;
  logic        ser_rx_done_i = 0, ser_tx_done_i = 0;
  logic [1:0]  ext_edge_i = 2'b00;
  logic        en_we_i = 0;
  logic [7:0]  en_wdata_i = 8'h00;
  logic [7:0]  en_rdata_o;
  logic [15:0] vec_addr_o;
  logic        irq_o;
  logic        ack_i = 0;
  logic [4:0]  taken_o;
  logic        reti_i = 0;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;  // 250 MHz

  irq_vec_ctrl dut (.*);

  task automatic step();
    @(posedge clk_i); #1;
  endtask

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", what, act, exp);
    end
  endtask

  task automatic wr_en(input logic [7:0] v);
    en_we_i = 1; en_wdata_i = v; step(); en_we_i = 0;
  endtask

  task automatic ret();
    reti_i = 1; step(); reti_i = 0;
  endtask

  task automatic service(input string tag, input logic [15:0] vexp, input logic [4:0] texp);
    check({tag, " R5 irq"}, 32'(irq_o), 1);
    check({tag, " R5 vec"}, 32'(vec_addr_o), 32'(vexp));
    ack_i = 1; step(); ack_i = 0;
    check({tag, " R9 irq low after ack"}, 32'(irq_o), 0);
    check({tag, " R8 taken"}, 32'(taken_o), 32'(texp));
    step();
    check({tag, " R8 taken one cycle"}, 32'(taken_o), 0);
    repeat (3) step();
    check({tag, " R9 quiet until reti"}, 32'(irq_o), 0);
  endtask

  task automatic t_reset();
    check("R1 en", 32'(en_rdata_o), 0);
    check("R1 irq", 32'(irq_o), 0);
    check("R1 taken", 32'(taken_o), 0);
    check("R1 vec", 32'(vec_addr_o), 0);
  endtask

  task automatic t_regrw();
    wr_en(8'hA5); check("R2 readback A5", 32'(en_rdata_o), 32'h A5);
    wr_en(8'h5A); check("R2 readback 5A", 32'(en_rdata_o), 32'h5A);
    wr_en(8'h00); check("R2 readback 00", 32'(en_rdata_o), 0);
  endtask

  task automatic t_global();
    tmr0_ovf_i = 1;
    wr_en(8'h1F);
    repeat (3) step();
    check("R3 global clear blocks", 32'(irq_o), 0);
    wr_en(8'h9F);
    check("R11 no irq at enable edge", 32'(irq_o), 0);
    step();
    check("R11 irq one cycle later", 32'(irq_o), 1);
    service("R5 tmr0", 16'h000B, 5'b00010);
    tmr0_ovf_i = 0; ret(); step();
    check("R9 idle after reti", 32'(irq_o), 0);
  endtask

  task automatic t_priority();
    ext_edge_i = 2'b01;
    ext0_req_i = 1; tmr0_ovf_i = 1; ext1_req_i = 1; tmr1_ovf_i = 1; ser_rx_done_i = 1;
    step();
    service("R6 ext0 edge", 16'h0003, 5'b00001);
    ext0_req_i = 0; ret(); step();
    service("R6 tmr0", 16'h000B, 5'b00010);
    tmr0_ovf_i = 0; ret(); step();
    service("R6 ext1 level", 16'h0013, 5'b00000);
    ext1_req_i = 0; ret(); step();
    service("R6 tmr1", 16'h001B, 5'b01000);
    tmr1_ovf_i = 0; ret(); step();
    service("R6 serial", 16'h0023, 5'b00000);
    ser_rx_done_i = 0; ret(); step();
    check("R6 all drained", 32'(irq_o), 0);
    ext_edge_i = 2'b00;
  endtask

  task automatic t_mask();
    wr_en(8'h82);
    ext0_req_i = 1; tmr0_ovf_i = 1;
    step();
    service("R4 ext0 masked", 16'h000B, 5'b00010);
    ext0_req_i = 0; tmr0_ovf_i = 0; ret(); step();
    check("R4 masked ext0 not issued", 32'(irq_o), 0);
  endtask

  task automatic t_serial();
    wr_en(8'h90);
    ser_rx_done_i = 1; step();
    service("R7 rx only", 16'h0023, 5'b00000);
    ser_rx_done_i = 0; ret();
    ser_tx_done_i = 1; step();
    service("R7 tx only", 16'h0023, 5'b00000);
    ser_tx_done_i = 0; ret(); step();
    check("R7 idle", 32'(irq_o), 0);
  endtask

  task automatic t_withdraw();
    wr_en(8'h81);
    ext_edge_i = 2'b01;
    ext0_req_i = 1; step();
    check("R10 irq up", 32'(irq_o), 1);
    ext0_req_i = 0; step();
    check("R10 irq withdrawn", 32'(irq_o), 0);
    check("R10 vec cleared", 32'(vec_addr_o), 0);
    check("R10 no taken", 32'(taken_o), 0);
    ext_edge_i = 2'b00;
  endtask

  initial begin
    #1;
    t_reset();
    repeat (2) step();
    rst_ni = 1;
    step();
    t_reset();
    t_regrw();
    t_global();
    t_priority();
    t_mask();
    t_serial();
    t_withdraw();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule